// File: doc/BRIEF.md
# Detector Event Formatter with Low-Energy Thinning

This block takes 16-bit detector event words, one per cycle when a valid strobe is high, from an already deserialized instrument link. Each word carries a detector number, two discriminator flags and a 12-bit energy. Events whose energy falls under a host-set threshold are thinned by a host-set ratio; every other event is kept. Kept events go into a first-word-fall-through FIFO that the host drains through a read strobe. Its occupancy, full and empty flags, and a count of events lost to a full FIFO are all visible to the host.

Alongside the event path, the block counts discriminator hits per detector in one counter for each flag. A once-per-second sync pulse copies all eight counters into a snapshot and clears them. The snapshot is then sent out as a second stream: eight consecutive tagged words.

Top module: `esf_event_formatter`

## Requirements
- R1: After a synchronous active-high reset, the FIFO is empty, fifo_count and ovf_count are 0, rate_valid is low, and the thinning phase starts at zero.
- R2: Event word layout is bits 15:14 detector number, bit 13 upper-discriminator flag, bit 12 lower-discriminator flag, and bits 11:0 energy. An event is low-energy when its energy is strictly less than low_thresh, so energy equal to the threshold counts as high.
- R3: High-energy events are always offered to the FIFO. With decim_ratio 0 or 1, every low-energy event is offered too.
- R4: With decim_ratio N of 2 or more, a phase counter advances on every valid low-energy event, including ones later dropped by a full FIFO. An event is kept when the phase is 0. The phase returns to 0 when it reaches N, or when it already equals or exceeds N. After reset, the first low event is kept, and then one of every N after it.
- R5: rd_data shows the oldest stored word whenever fifo_empty is low, and words leave in arrival order. A rd_en while the FIFO is empty has no effect.
- R6: A kept event that arrives while fifo_full is high is discarded, even if a read happens in the same cycle. In that case ovf_count increments, saturating at 65535.
- R7: Every valid event increments its detector's lower counter when bit 12 is set and its upper counter when bit 13 is set. This happens whether or not the event is thinned or dropped. The counters are 16 bits and saturate at 65535.
- R8: On sync_1hz, all eight counters are copied to the snapshot and the live counters restart. An event in the same cycle as the sync is counted in the new interval and not in the snapshot.
- R9: From the cycle after a sync, rate_valid stays high for 8 cycles. rate_tag runs 0 to 7, where tag = 2×detector + (1 for upper, 0 for lower), and rate_word holds that snapshot counter. A sync during the stream restarts it at tag 0.
- R10: fifo_count equals the number of stored words. fifo_full is high exactly when fifo_count equals DEPTH (16 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event word strobe |
| evt_word | input | 16 | Event word |
| low_thresh | input | 12 | Low-energy threshold |
| decim_ratio | input | 8 | Keep one of N low-energy events |
| sync_1hz | input | 1 | Interval sync pulse |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 16 | Oldest stored event |
| fifo_empty | output | 1 | FIFO empty |
| fifo_full | output | 1 | FIFO full |
| fifo_count | output | 5 | FIFO occupancy |
| ovf_count | output | 16 | Events dropped at full FIFO |
| rate_valid | output | 1 | Rate stream word valid |
| rate_tag | output | 3 | Rate word slot |
| rate_word | output | 16 | Rate counter value |

## Verification
The sync pulse and an event can land on the same edge. The bench forces this and then checks that the event appears in the next snapshot rather than the one just taken. A read and a write can also meet at a full FIFO. Long floods followed by reads provoke this, and a cycle-accurate bench model judges occupancy and the drop counter. The random phase mixes syncs, reads and thinned events on every cycle and compares every output each cycle.

// File: rtl/esf_pkg.sv
package esf_pkg;
    localparam int EVT_W  = 16;
    localparam int ENG_W  = 12;
    localparam int DET_W  = 2;
    localparam int NDET   = 1 << DET_W;
    localparam int CNT_W  = 16;
    localparam int NSLOT  = 2 * NDET;
    localparam int TAG_W  = $clog2(NSLOT);

    typedef struct packed {
        logic [DET_W-1:0] det;
        logic             uld;
        logic             lld;
        logic [ENG_W-1:0] energy;
    } evt_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
    endfunction
endpackage

// File: rtl/esf_decimator.sv
module esf_decimator
    import esf_pkg::*;
#(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_valid,
    input  evt_t               evt,
    input  logic [ENG_W-1:0]   low_thresh,
    input  logic [RATIO_W-1:0] decim_ratio,
    output logic               keep
);
    logic [RATIO_W-1:0] phase;
    logic [RATIO_W:0]   phase_nx;
    logic [RATIO_W:0]   eff_n;
    logic               is_low;

    always_comb begin
        is_low   = evt.energy < low_thresh;
        eff_n    = (decim_ratio == '0) ? {{RATIO_W{1'b0}}, 1'b1} : {1'b0, decim_ratio};
        phase_nx = {1'b0, phase} + 1'b1;
        keep     = evt_valid && (!is_low || phase == '0 || eff_n == 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (evt_valid && is_low) begin
            if (phase_nx >= eff_n) phase <= '0;
            else                   phase <= phase_nx[RATIO_W-1:0];
        end
    end
endmodule

// File: rtl/esf_fifo.sv
module esf_fifo
    import esf_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_req,
    input  logic [W-1:0]             wr_data,
    input  logic                     rd_en,
    output logic [W-1:0]             rd_data,
    output logic                     empty,
    output logic                     full,
    output logic [$clog2(DEPTH):0]   count,
    output logic [CNT_W-1:0]         drops
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          wr_ok, rd_ok;

    always_comb begin
        empty   = (count == '0);
        full    = (count == DEPTH[AW:0]);
        wr_ok   = wr_req && !full;
        rd_ok   = rd_en && !empty;
        rd_data = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            drops <= '0;
        end else begin
            if (wr_ok) wp <= wp + 1'b1;
            if (rd_ok) rp <= rp + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr_req && full) drops <= sat_inc(drops);
        end
    end
endmodule

// File: rtl/esf_rate_bank.sv
module esf_rate_bank
    import esf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_valid,
    input  evt_t             evt,
    input  logic             sync,
    output logic             rate_valid,
    output logic [TAG_W-1:0] rate_tag,
    output logic [CNT_W-1:0] rate_word
);
    logic [CNT_W-1:0] live [NSLOT];
    logic [CNT_W-1:0] snap [NSLOT];
    logic             active;
    logic [TAG_W-1:0] idx;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic hit;
        always_comb begin
            hit = evt_valid && (evt.det == DET_W'(s / 2)) &&
                  ((s % 2 == 1) ? evt.uld : evt.lld);
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                live[s] <= '0;
                snap[s] <= '0;
            end else if (sync) begin
                snap[s] <= live[s];
                live[s] <= hit ? CNT_W'(1) : '0;
            end else if (hit) begin
                live[s] <= sat_inc(live[s]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (sync) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (active) begin
            if (idx == TAG_W'(NSLOT - 1)) active <= 1'b0;
            else                          idx    <= idx + 1'b1;
        end
    end

    always_comb begin
        rate_valid = active;
        rate_tag   = idx;
        rate_word  = snap[idx];
    end
endmodule

// File: rtl/esf_event_formatter.sv
module esf_event_formatter
    import esf_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int RATIO_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   evt_valid,
    input  logic [15:0]            evt_word,
    input  logic [11:0]            low_thresh,
    input  logic [RATIO_W-1:0]     decim_ratio,
    input  logic                   sync_1hz,
    input  logic                   rd_en,
    output logic [15:0]            rd_data,
    output logic                   fifo_empty,
    output logic                   fifo_full,
    output logic [$clog2(DEPTH):0] fifo_count,
    output logic [15:0]            ovf_count,
    output logic                   rate_valid,
    output logic [2:0]             rate_tag,
    output logic [15:0]            rate_word
);
    evt_t evt;
    logic keep_w;

    assign evt = evt_t'(evt_word);

    esf_decimator #(.RATIO_W(RATIO_W)) u_dec (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt(evt),
        .low_thresh(low_thresh), .decim_ratio(decim_ratio), .keep(keep_w)
    );

    esf_fifo #(.W(EVT_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .wr_req(keep_w), .wr_data(evt_word),
        .rd_en(rd_en), .rd_data(rd_data), .empty(fifo_empty),
        .full(fifo_full), .count(fifo_count), .drops(ovf_count)
    );

    esf_rate_bank u_rate (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt(evt),
        .sync(sync_1hz), .rate_valid(rate_valid), .rate_tag(rate_tag),
        .rate_word(rate_word)
    );
endmodule

// File: rtl/esf_checker.sv
module esf_checker #(
    parameter int DEPTH   = 16,
    parameter int RATIO_W = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   evt_valid,
    input logic [15:0]            evt_word,
    input logic [11:0]            low_thresh,
    input logic [RATIO_W-1:0]     decim_ratio,
    input logic                   sync_1hz,
    input logic                   rd_en,
    input logic                   keep,
    input logic                   fifo_empty,
    input logic                   fifo_full,
    input logic [$clog2(DEPTH):0] fifo_count,
    input logic [15:0]            ovf_count,
    input logic                   rate_valid,
    input logic [2:0]             rate_tag
);
    assert_high_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_word[11:0] >= low_thresh) |-> keep);

    assert_ratio_one_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && decim_ratio <= 1) |-> keep);

    assert_drop_counts_R6: assert property (@(posedge clk) disable iff (rst)
        (keep && fifo_full && ovf_count != 16'hFFFF) |=> ovf_count == $past(ovf_count) + 16'd1);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (!(keep && fifo_full)) |=> $stable(ovf_count));

    assert_read_drains_R10: assert property (@(posedge clk) disable iff (rst)
        (!keep && rd_en && !fifo_empty) |=> fifo_count == $past(fifo_count) - 1'b1);

    assert_empty_read_R5: assert property (@(posedge clk) disable iff (rst)
        (!keep && fifo_empty) |=> fifo_empty);

    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

    assert_stream_start_R9: assert property (@(posedge clk) disable iff (rst)
        sync_1hz |=> (rate_valid && rate_tag == 3'd0));
endmodule

bind esf_event_formatter esf_checker #(.DEPTH(DEPTH), .RATIO_W(RATIO_W)) u_chk (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_word(evt_word),
    .low_thresh(low_thresh), .decim_ratio(decim_ratio), .sync_1hz(sync_1hz),
    .rd_en(rd_en), .keep(keep_w), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .fifo_count(fifo_count), .ovf_count(ovf_count), .rate_valid(rate_valid),
    .rate_tag(rate_tag)
);

// File: tb/tb_esf_event_formatter.sv
module tb_esf_event_formatter;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          evt_valid;
    logic [15:0]   evt_word;
    logic [11:0]   low_thresh;
    logic [7:0]    decim_ratio;
    logic          sync_1hz;
    logic          rd_en;
    logic [15:0]   rd_data;
    logic          fifo_empty, fifo_full;
    logic [CW-1:0] fifo_count;
    logic [15:0]   ovf_count;
    logic          rate_valid;
    logic [2:0]    rate_tag;
    logic [15:0]   rate_word;

    always #5 clk = ~clk;

    esf_event_formatter #(.DEPTH(DEPTH), .RATIO_W(8)) dut (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_word(evt_word),
        .low_thresh(low_thresh), .decim_ratio(decim_ratio), .sync_1hz(sync_1hz),
        .rd_en(rd_en), .rd_data(rd_data), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .fifo_count(fifo_count), .ovf_count(ovf_count),
        .rate_valid(rate_valid), .rate_tag(rate_tag), .rate_word(rate_word)
    );

    int checks = 0;
    int errors = 0;

    logic [15:0] q[$];
    int phase, ovf, idx;
    int live[8];
    int snap[8];
    bit emit;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit model_keep(logic [15:0] w);
        int n;
        bit k;
        n = (decim_ratio == 0) ? 1 : int'(decim_ratio);
        if (w[11:0] >= low_thresh) return 1'b1;
        k = (phase == 0) || (n == 1);
        phase = (phase + 1 >= n) ? 0 : phase + 1;
        return k;
    endfunction

    task automatic model_reset();
        q.delete();
        phase = 0; ovf = 0; idx = 0; emit = 0;
        for (int s = 0; s < 8; s++) begin live[s] = 0; snap[s] = 0; end
    endtask

    task automatic compare_all();
        chk("R10 count", int'(fifo_count), q.size());
        chk("R10 full", int'(fifo_full), int'(q.size() == DEPTH));
        chk("R5 empty", int'(fifo_empty), int'(q.size() == 0));
        if (q.size() > 0) chk("R5 head data", int'(rd_data), int'(q[0]));
        chk("R6 drop count", int'(ovf_count), ovf);
        chk("R9 valid", int'(rate_valid), int'(emit));
        if (emit) begin
            chk("R9 tag", int'(rate_tag), idx);
            chk("R9 word", int'(rate_word), snap[idx]);
        end
    endtask

    task automatic step(bit v, logic [15:0] w, bit rd, bit sy);
        int pre;
        bit k;
        compare_all();
        evt_valid = v; evt_word = w; rd_en = rd; sync_1hz = sy;
        @(posedge clk);
        pre = q.size();
        k = v ? model_keep(w) : 1'b0;
        if (rd && pre > 0) void'(q.pop_front());
        if (k) begin
            if (pre < DEPTH) q.push_back(w);
            else if (ovf < 65535) ovf++;
        end
        if (sy) begin
            for (int s = 0; s < 8; s++) begin snap[s] = live[s]; live[s] = 0; end
            emit = 1; idx = 0;
        end else if (emit) begin
            if (idx == 7) emit = 0; else idx++;
        end
        if (v) begin
            if (w[12] && live[2*w[15:14]] < 65535) live[2*w[15:14]]++;
            if (w[13] && live[2*w[15:14]+1] < 65535) live[2*w[15:14]+1]++;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; evt_valid = 0; evt_word = '0; rd_en = 0; sync_1hz = 0;
        low_thresh = 12'h800; decim_ratio = 8'd3;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 empty", int'(fifo_empty), 1);
        chk("R1 count", int'(fifo_count), 0);
        chk("R1 ovf", int'(ovf_count), 0);
        chk("R1 rate_valid", int'(rate_valid), 0);

        // R4: ratio 3, seven low events keep the 1st, 4th, 7th
        for (int i = 0; i < 7; i++) step(1, {4'b0000, 12'h010 + 12'(i)}, 0, 0);
        chk("R4 kept one of three", int'(fifo_count), 3);
        // R2: energy equal to threshold is high-energy
        step(1, {4'b0000, 12'h800}, 0, 0);
        chk("R2 threshold boundary kept", int'(fifo_count), 4);
        // R3: ratio 0 keeps every low event despite odd phase
        decim_ratio = 8'd0;
        for (int i = 0; i < 3; i++) step(1, {4'b0100, 12'h001}, 0, 0);
        chk("R3 ratio zero keeps all", int'(fifo_count), 7);
        for (int i = 0; i < 8; i++) step(0, '0, 1, 0);
        chk("R5 empty after drain", int'(fifo_empty), 1);

        // R8: event in the sync cycle lands in the new interval
        step(1, {2'd1, 2'b01, 12'hFFF}, 0, 1);
        for (int i = 0; i < 9; i++) step(0, '0, 1, 0);
        step(0, '0, 0, 1);
        step(0, '0, 0, 0);
        step(0, '0, 0, 0);
        chk("R8 new interval tag", int'(rate_tag), 2);
        chk("R8 new interval count", int'(rate_word), 1);
        // R9: sync mid-stream restarts at tag 0
        step(0, '0, 0, 1);
        chk("R9 restart tag", int'(rate_tag), 0);
        chk("R9 restart valid", int'(rate_valid), 1);

        // R6/R7 flood: saturate drop count and rate counter
        low_thresh = 12'h000; decim_ratio = 8'd1;
        for (int i = 0; i < 70000; i++) step(1, {2'd0, 2'b11, 12'h123}, 0, 0);
        chk("R6 drop saturates", int'(ovf_count), 65535);
        chk("R10 full at depth", int'(fifo_full), 1);
        step(1, {2'd0, 2'b00, 12'h555}, 1, 0);
        chk("R6 write lost with read", int'(fifo_count), DEPTH - 1);
        step(0, '0, 0, 1);
        chk("R7 lower saturates", int'(rate_word), 65535);
        step(0, '0, 0, 0);
        chk("R7 upper saturates", int'(rate_word), 65535);
        for (int i = 0; i < 20; i++) step(0, '0, 1, 0);
        chk("R5 read on empty ignored", int'(fifo_count), 0);

        // random mix
        for (int i = 0; i < 5000; i++) begin
            if (i % 250 == 0) begin
                low_thresh  = 12'($urandom_range(0, 4095));
                decim_ratio = 8'($urandom_range(0, 5));
            end
            step(($urandom_range(0, 9) < 6), 16'($urandom),
                 ($urandom_range(0, 9) < 4), ($urandom_range(0, 299) == 0));
        end
        compare_all();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule